// File: doc/BRIEF.md
# Multi-Port Request Front End with Retry Tracking

This block sits between several requester ports and a single blocking engine that serves one request at a time. Each port has a request channel and a response channel. On the request channel the requester raises `req_valid`. The block either accepts the request in that same cycle (`req_ready` high) or refuses it. A refused requester is told later, through a one-cycle `req_retry` pulse, that it may try again. On the response channel the block offers a response with `rsp_valid`. The requester takes it with `rsp_ready` or refuses it. A refused response stays in the port. The port sends it again when the requester pulses `rsp_retry`.

Back-pressure rules:
- A request counts as a transfer only in a cycle where both `req_valid` and `req_ready` are high. Every other valid cycle is a refusal, and the port then owes that requester a retry.
- A response counts as delivered only in a cycle where both `rsp_valid` and `rsp_ready` are high.
- A response is offered exactly once per attempt. The block does not keep `rsp_valid` up while waiting for a refused response to be taken.

The block records which port owns the outstanding request and routes the engine's result to that port. A port waits for its owed retry until it holds no response. The retry is raised after a response completes, or after that port resends a held response successfully. The engine is external. The block starts it with `eng_start`, and the engine answers with `eng_done` and its result on `eng_rdata` one or more cycles later.

Top module: `mport_retry_arb`

## Requirements
- R1: `eng_start` fires only when the engine is idle or is finishing (`eng_done` high) in that cycle. While the engine is busy and not finishing, every `req_ready` is low. `eng_wdata` carries the accepted port's `req_data` slice, where port i occupies bits [i*DW +: DW].
- R2: Among ports that present a request and are eligible while the engine can accept, only the lowest-indexed port gets `req_ready`. Each other requesting port is refused and becomes owed a retry.
- R3: A port that holds a refused response, or that already owes a retry, refuses a new request and owes a retry.
- R4: A request refused only because the engine was occupied makes its port owed a retry.
- R5: In the `eng_done` cycle, the owning port raises `rsp_valid` with `rsp_data` equal to `eng_rdata`. In that same cycle a new request can be accepted.
- R6: A response refused by its requester is held. In any later cycle where `rsp_retry` is high, the port raises `rsp_valid` again with the same data. That resend may also be refused, and the data is then still held.
- R7: `req_retry` pulses for one cycle, in the cycle after an `eng_done` cycle or after a successful resend by that port. It pulses only for a port that owes a retry and holds no response after that cycle. The pulse clears the owed flag.
- R8: `rsp_retry` on a port that holds nothing has no effect. That port's `rsp_valid` stays low.
- R9: After reset, no response is held, no retry is owed, the engine is idle, and all outputs are low.
- R10: A response is never delivered to a port that is still holding an earlier one. A port whose fresh response is refused cannot accept a new request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NP | Request present, one bit per port |
| req_ready | output | NP | Request accepted this cycle |
| req_data | input | NP*DW | Request payloads, port i at [i*DW +: DW] |
| req_retry | output | NP | One-cycle pulse: requester may try again |
| rsp_valid | output | NP | Response offered this cycle |
| rsp_ready | input | NP | Requester takes the offered response |
| rsp_data | output | NP*DW | Response payloads, port i at [i*DW +: DW] |
| rsp_retry | input | NP | Requester asks for a held response again |
| eng_start | output | 1 | Start the engine with the accepted request |
| eng_wdata | output | DW | Payload of the accepted request |
| eng_done | input | 1 | Engine finishes the outstanding request |
| eng_rdata | input | DW | Engine result, valid with eng_done |

## Verification
The signals `req_ready`, `eng_start`, `eng_wdata`, `rsp_valid` and `rsp_data` depend combinationally on the cycle's inputs. The bench drives inputs on the falling edge and compares these outputs 2 ns later, in the same cycle. `req_retry` is registered. It is due one cycle after its triggering `eng_done` or successful resend, so the bench predicts it at the edge and compares it during the next cycle. The bench's engine stand-in raises `eng_done` between one and four cycles after a start. The directed sequence pins the latency so that the R3–R8 corners fall on known cycles.

// File: rtl/mport_retry_pkg.sv
package mport_retry_pkg;

  // width of a port index; at least one bit even for a single port
  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mport_prio_pick.sv
module mport_prio_pick #(
  parameter int unsigned NP  = 4,
  parameter int unsigned IDW = 2
) (
  input  logic [NP-1:0]  cand,
  output logic [NP-1:0]  pick,
  output logic [IDW-1:0] pick_id,
  output logic           any
);

  logic [NP:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < NP; g++) begin : g_chain
    assign pick[g]    = cand[g] & ~taken[g];
    assign taken[g+1] = taken[g] | cand[g];
  end

  assign any = taken[NP];

  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    pick_id = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (cand[i]) pick_id = IDW'(i);
    end
  end

endmodule

// File: rtl/mport_eng_track.sv
module mport_eng_track #(
  parameter int unsigned IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IDW-1:0] start_id,
  input  logic           done,
  output logic           busy,
  output logic [IDW-1:0] owner,
  output logic           avail
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      owner <= start_id;
    end else if (done) begin
      busy  <= 1'b0;
    end
  end

  // the engine frees itself before the response goes out
  assign avail = ~busy | done;

endmodule

// File: rtl/mport_port_slot.sv
module mport_port_slot #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deliver,
  input  logic          eng_done,
  input  logic [DW-1:0] rdata,
  input  logic          rsp_ready,
  input  logic          rsp_retry,
  input  logic          req_valid,
  input  logic          granted,
  output logic          free,
  output logic          held,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          req_retry
);

  logic          held_q, owe_q, retry_q;
  logic [DW-1:0] hdat_q;
  logic          resend, resend_ok, fresh_refused;
  logic          held_n, owe_pre, fire;

  assign resend        = held_q & rsp_retry;
  assign resend_ok     = resend & rsp_ready;
  assign fresh_refused = deliver & ~rsp_ready;

  // a port whose fresh response bounces this cycle must not take new work
  assign free      = ~held_q & ~owe_q & ~fresh_refused;
  assign rsp_valid = deliver | resend;
  assign rsp_data  = deliver ? rdata : hdat_q;

  assign held_n  = held_q ? ~resend_ok : fresh_refused;
  assign owe_pre = owe_q | (req_valid & ~granted);
  assign fire    = (eng_done | resend_ok) & owe_pre & ~held_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owe_q   <= 1'b0;
      retry_q <= 1'b0;
      hdat_q  <= '0;
    end else begin
      held_q  <= held_n;
      owe_q   <= owe_pre & ~fire;
      retry_q <= fire;
      if (fresh_refused) hdat_q <= rdata;
    end
  end

  assign held      = held_q;
  assign req_retry = retry_q;

endmodule

// File: rtl/mport_retry_arb.sv
module mport_retry_arb #(
  parameter int unsigned NP = 4,
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  output logic [NP-1:0]    req_ready,
  input  logic [NP*DW-1:0] req_data,
  output logic [NP-1:0]    req_retry,
  output logic [NP-1:0]    rsp_valid,
  input  logic [NP-1:0]    rsp_ready,
  output logic [NP*DW-1:0] rsp_data,
  input  logic [NP-1:0]    rsp_retry,
  output logic             eng_start,
  output logic [DW-1:0]    eng_wdata,
  input  logic             eng_done,
  input  logic [DW-1:0]    eng_rdata
);

  localparam int unsigned IDW = mport_retry_pkg::id_width(NP);

  if (NP < 1 || NP > 8) begin : g_np_bad
    $error("mport_retry_arb: NP must be within 1..8");
  end

  logic           busy, avail, any_pick;
  logic [IDW-1:0] owner, pick_id;
  logic [NP-1:0]  free, held, cand, pick, deliver;

  mport_eng_track #(.IDW(IDW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (any_pick),
    .start_id (pick_id),
    .done     (eng_done),
    .busy     (busy),
    .owner    (owner),
    .avail    (avail)
  );

  assign cand = req_valid & free & {NP{avail}};

  mport_prio_pick #(.NP(NP), .IDW(IDW)) u_pick (
    .cand    (cand),
    .pick    (pick),
    .pick_id (pick_id),
    .any     (any_pick)
  );

  assign req_ready = pick;
  assign eng_start = any_pick;

  always_comb begin
    eng_wdata = '0;
    for (int i = 0; i < NP; i++) begin
      if (pick[i]) eng_wdata = req_data[i*DW +: DW];
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign deliver[g] = eng_done & (owner == IDW'(g));

    mport_port_slot #(.DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .deliver   (deliver[g]),
      .eng_done  (eng_done),
      .rdata     (eng_rdata),
      .rsp_ready (rsp_ready[g]),
      .rsp_retry (rsp_retry[g]),
      .req_valid (req_valid[g]),
      .granted   (pick[g]),
      .free      (free[g]),
      .held      (held[g]),
      .rsp_valid (rsp_valid[g]),
      .rsp_data  (rsp_data[g*DW +: DW]),
      .req_retry (req_retry[g])
    );
  end

endmodule

// File: rtl/mport_retry_arb_chk.sv
module mport_retry_arb_chk #(
  parameter int unsigned NP  = 4,
  parameter int unsigned IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NP-1:0]  req_valid,
  input logic [NP-1:0]  req_ready,
  input logic [NP-1:0]  req_retry,
  input logic [NP-1:0]  rsp_valid,
  input logic [NP-1:0]  rsp_ready,
  input logic [NP-1:0]  rsp_retry,
  input logic           eng_start,
  input logic           eng_done,
  input logic           busy,
  input logic [IDW-1:0] owner,
  input logic [NP-1:0]  held
);

  // R1
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |-> !eng_start);

  // R1
  done_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> busy);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  for (genvar g = 0; g < NP; g++) begin : g_chk
    // R2
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[g] |-> req_valid[g]);

    // R3
    held_port_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held[g] |-> !req_ready[g]);

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[g] && !(rsp_retry[g] && rsp_ready[g])) |=> held[g]);

    // R7
    retry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_retry[g] |-> !held[g]);

    // R8
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!held[g] && !(eng_done && owner == IDW'(g))) |-> !rsp_valid[g]);

    // R10
    no_double_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && owner == IDW'(g)) |-> !held[g]);
  end

endmodule

bind mport_retry_arb mport_retry_arb_chk #(.NP(NP), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_retry (req_retry),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_retry (rsp_retry),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .busy      (busy),
  .owner     (owner),
  .held      (held)
);

// File: tb/mport_retry_arb_test.sv
`timescale 1ns/1ps
module mport_retry_arb_test;

  localparam int NP = 4;
  localparam int DW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0, req_ready, req_retry, rsp_valid;
  logic [NP-1:0]    rsp_ready = '0, rsp_retry = '0;
  logic [NP*DW-1:0] req_data = '0, rsp_data;
  logic             eng_start, eng_done = 1'b0;
  logic [DW-1:0]    eng_wdata, eng_rdata = '0;

  always #10 clk = ~clk;

  mport_retry_arb #(.NP(NP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_retry(req_retry), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_retry(rsp_retry), .eng_start(eng_start),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // expected-behaviour model state
  logic          m_busy = 1'b0;
  int            m_owner = 0;
  int            m_lat = 0;
  int            lat_force = -1;
  logic [NP-1:0] m_held = '0, m_owe = '0, m_retry = '0;
  logic [DW-1:0] m_hdat [NP];
  logic [NP-1:0] obs_ready, obs_retry, obs_rvld;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic [NP-1:0] v, input logic [NP-1:0] rdy,
                      input logic [NP-1:0] rt);
    logic [NP*DW-1:0] rd;
    logic [NP-1:0] dl, fr, gr, hn, op, tg, fi, ev;
    logic [DW-1:0] er;
    logic dn, av;
    int gid;
    for (int i = 0; i < NP; i++) rd[i*DW +: DW] = DW'($urandom);
    dn = m_busy && (m_lat == 0);
    er = DW'($urandom);
    req_valid = v; req_data = rd; rsp_ready = rdy; rsp_retry = rt;
    eng_done = dn; eng_rdata = er;
    #2;
    av = !m_busy || dn;
    gid = -1; gr = '0;
    for (int i = 0; i < NP; i++) begin
      dl[i] = dn && (m_owner == i);
      fr[i] = !m_held[i] && !m_owe[i] && !(dl[i] && !rdy[i]);
      if (gid < 0 && av && v[i] && fr[i]) begin gid = i; gr[i] = 1'b1; end
      ev[i] = dl[i] | (m_held[i] & rt[i]);
    end
    obs_ready = req_ready; obs_retry = req_retry; obs_rvld = rsp_valid;
    chk("R2", "req_ready", 64'(req_ready), 64'(gr));
    chk("R1", "eng_start", 64'(eng_start), 64'(gid >= 0));
    if (gid >= 0) chk("R1", "eng_wdata", 64'(eng_wdata), 64'(rd[gid*DW +: DW]));
    chk("R5", "rsp_valid", 64'(rsp_valid), 64'(ev));
    chk("R7", "req_retry", 64'(req_retry), 64'(m_retry));
    for (int i = 0; i < NP; i++) begin
      if (ev[i]) chk("R6", "rsp_data", 64'(rsp_data[i*DW +: DW]),
                     64'(dl[i] ? er : m_hdat[i]));
      if (dl[i]) chk("R10", "held at delivery", 64'(m_held[i]), 64'(0));
      hn[i] = m_held[i] ? !(rt[i] && rdy[i]) : (dl[i] && !rdy[i]);
      op[i] = m_owe[i] | (v[i] & !gr[i]);
      tg[i] = dn | (m_held[i] & rt[i] & rdy[i]);
      fi[i] = tg[i] & op[i] & !hn[i];
    end
    @(posedge clk);
    for (int i = 0; i < NP; i++) if (dl[i] && !rdy[i]) m_hdat[i] = er;
    m_held = hn; m_owe = op & ~fi; m_retry = fi;
    if (gid >= 0) begin
      m_busy = 1'b1; m_owner = gid;
      m_lat = (lat_force >= 0) ? lat_force : int'($urandom_range(0, 3));
    end else if (dn) m_busy = 1'b0;
    else if (m_busy) m_lat--;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) m_hdat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R9 reset state
    chk("R9", "req_ready", 64'(req_ready), 64'(0));
    chk("R9", "rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R9", "req_retry", 64'(req_retry), 64'(0));
    chk("R9", "eng_start", 64'(eng_start), 64'(0));
    @(negedge clk);

    lat_force = 2;
    step(4'b1111, 4'b1111, 4'b0000);
    chk("R2", "lowest index wins", 64'(obs_ready), 64'(4'b0001));
    step(4'b0010, 4'b1111, 4'b0000);
    chk("R4", "busy engine refuses", 64'(obs_ready), 64'(0));
    step(4'b0000, 4'b0000, 4'b0000);
    step(4'b0000, 4'b0000, 4'b0000);
    chk("R5", "delivery to owner", 64'(obs_rvld), 64'(4'b0001));
    step(4'b0001, 4'b1111, 4'b0000);
    chk("R7", "retries after done", 64'(obs_retry), 64'(4'b1110));
    chk("R3", "holding port refuses", 64'(obs_ready), 64'(0));
    step(4'b0000, 4'b0000, 4'b0001);
    chk("R6", "resend refused", 64'(obs_rvld), 64'(4'b0001));
    step(4'b0000, 4'b0001, 4'b0001);
    chk("R6", "resend taken", 64'(obs_rvld), 64'(4'b0001));
    step(4'b0000, 4'b1111, 4'b1110);
    chk("R7", "retry after resend", 64'(obs_retry), 64'(4'b0001));
    chk("R8", "retry with nothing held", 64'(obs_rvld), 64'(0));
    lat_force = 0;
    step(4'b0100, 4'b1111, 4'b0000);
    step(4'b1000, 4'b1111, 4'b0000);
    chk("R5", "response in done cycle", 64'(obs_rvld), 64'(4'b0100));
    chk("R5", "accept in done cycle", 64'(obs_ready), 64'(4'b1000));

    lat_force = -1;
    for (int n = 0; n < 3000; n++) begin
      logic [NP-1:0] v, r, t;
      v = NP'($urandom) & NP'($urandom);
      r = NP'($urandom) | NP'($urandom);
      t = NP'($urandom);
      step(v, r, t);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule